// File: doc/BRIEF.md
# Digit-Decomposed 64x64 Unsigned Multiplier

This block forms the full 128-bit unsigned product of two 64-bit operands. It splits each operand into eight 8-bit digits, and the digits reach the sub-multipliers through a four-way fan-out. Each 64-bit word breaks into four 16-bit quarters, each quarter into four 4-bit groups, and two adjacent groups make one digit. Every pair of digits feeds its own 8x8 sub-multiplier. The sixty-four 16-bit sub-products are laid into bit columns at offset 8·(i+j).

Three levels of small parallel counters then compress those columns. The counters are 3-output counters of up to seven inputs, which include the six-input form, and 2-output counters of two or three inputs. After the third level every column holds at most two bits, and one carry-propagate adder adds the two remaining rows.

The core has no clock. Two parameters add an operand register and a product register. Both share one clock and a synchronous active-high reset, and both are on by default, which gives a two-cycle latency.

Top module: `digit_mult64`

## Requirements
- R1: For any operand pair, the output equals the exact 128-bit unsigned product of `a_i` and `b_i`.
- R2: With both register stages enabled, a product appears two rising edges after its operands are sampled. Until then, the output keeps the previous product.
- R3: While `rst` is high, the output reads zero from the first rising edge onward, whatever the operands are. After release, the operands present are multiplied normally.
- R4: If either operand is zero, the product is zero.
- R5: All-ones times all-ones gives 128'hFFFFFFFFFFFFFFFE0000000000000001.
- R6: Operands with a single set bit at positions p and q give a product with exactly one set bit, at position p+q.
- R7: If operand a has only digit i (bits 8i+7..8i) set to 0xFF and operand b has only digit j set to 0xFF, the product is 0xFE01 shifted left by 8·(i+j).
- R8: Swapping the two operands does not change the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stages |
| rst | input | 1 | Synchronous active-high reset of both register stages |
| a_i | input | 64 | Multiplicand |
| b_i | input | 64 | Multiplier |
| prod_o | output | 128 | Unsigned product |

## Verification
Single-digit 0xFF operands place one sub-product at every possible column offset, so a misplaced partial product or a wrong column slot shows up at once. Single-bit operands reveal any stray bit or lost carry as a wrong popcount. Dense patterns such as all-ones, repeated 0x01 digits and alternating bits load every column to its full height and drive long carry chains through all three counter levels and the final adder. Random pairs, operand swaps and a mid-run reset separate general arithmetic faults from asymmetries between the two operand paths and from timing faults in the register stages.

// File: rtl/dm_pkg.sv
package dm_pkg;

    parameter int DIGIT_W = 8;
    parameter int N_DIG   = 8;

    localparam int OP_W        = DIGIT_W * N_DIG;
    localparam int PROD_W      = 2 * OP_W;
    localparam int PP_W        = 2 * DIGIT_W;
    localparam int BRANCH      = 4;
    localparam int QUART_W     = OP_W / BRANCH;
    localparam int GROUP_W     = QUART_W / BRANCH;
    localparam int DIG_PER_Q   = QUART_W / DIGIT_W;
    localparam int GRP_PER_DIG = DIGIT_W / GROUP_W;
    localparam int COL_H0      = 2 * N_DIG - 1;
    localparam int CNT3_IN     = 7;

    typedef logic [OP_W-1:0]    operand_t;
    typedef logic [PROD_W-1:0]  product_t;
    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [PP_W-1:0]    subprod_t;

    typedef struct packed {
        operand_t mcand;
        operand_t mplier;
    } op_pair_t;

    // Digit d taken through the quarter / group fan-out tree.
    function automatic digit_t tree_digit(operand_t op, int d);
        logic [QUART_W-1:0] quarter;
        digit_t dig;
        quarter = op[(d / DIG_PER_Q) * QUART_W +: QUART_W];
        for (int g = 0; g < GRP_PER_DIG; g++) begin
            dig[g*GROUP_W +: GROUP_W] =
                quarter[((d % DIG_PER_Q) * GRP_PER_DIG + g) * GROUP_W +: GROUP_W];
        end
        return dig;
    endfunction

    // Smallest first-operand digit index on anti-diagonal s.
    function automatic int diag_lo(int s);
        return (s > N_DIG - 1) ? s - (N_DIG - 1) : 0;
    endfunction

    // Shape of one counter level for a column of h slots.
    function automatic int st_full(int h);
        return h / CNT3_IN;
    endfunction

    function automatic int st_rem(int h);
        return h % CNT3_IN;
    endfunction

    function automatic int st_n3(int h);
        return st_full(h) + ((st_rem(h) >= 4) ? 1 : 0);
    endfunction

    function automatic int st_n2(int h);
        return (st_rem(h) == 2 || st_rem(h) == 3) ? 1 : 0;
    endfunction

    function automatic int st_n1(int h);
        return (st_rem(h) == 1) ? 1 : 0;
    endfunction

    function automatic int st_own(int h);
        return st_n3(h) + st_n2(h) + st_n1(h);
    endfunction

    function automatic int st_up1(int h);
        return st_n3(h) + st_n2(h);
    endfunction

    function automatic int st_out(int h);
        return st_own(h) + st_up1(h) + st_n3(h);
    endfunction

    // Number of set bits in v[lo +: n].
    function automatic int count_range(logic [COL_H0-1:0] v, int lo, int n);
        int acc;
        acc = 0;
        for (int k = 0; k < COL_H0; k++) begin
            if (k >= lo && k < lo + n && v[k]) acc++;
        end
        return acc;
    endfunction

endpackage

// File: rtl/digit_mul.sv
module digit_mul
    import dm_pkg::*;
(
    input  digit_t   x_i,
    input  digit_t   y_i,
    output subprod_t p_o
);
    assign p_o = PP_W'(x_i) * PP_W'(y_i);
endmodule

// File: rtl/pp_gather.sv
module pp_gather
    import dm_pkg::*;
(
    input  operand_t          op_a_i,
    input  operand_t          op_b_i,
    output logic [COL_H0-1:0] cols_o [PROD_W]
);
    subprod_t pp [N_DIG][N_DIG];

    for (genvar i = 0; i < N_DIG; i++) begin : g_row
        for (genvar j = 0; j < N_DIG; j++) begin : g_col
            digit_mul u_dm (
                .x_i (tree_digit(op_a_i, i)),
                .y_i (tree_digit(op_b_i, j)),
                .p_o (pp[i][j])
            );
        end
    end

    // Low halves fill slots from the bottom, high halves from the top, so
    // the two anti-diagonals sharing a column never collide.
    always_comb begin
        for (int c = 0; c < PROD_W; c++) cols_o[c] = '0;
        for (int i = 0; i < N_DIG; i++) begin
            for (int j = 0; j < N_DIG; j++) begin
                for (int k = 0; k < PP_W; k++) begin
                    if (k < DIGIT_W)
                        cols_o[DIGIT_W*(i+j) + k][i - diag_lo(i+j)] = pp[i][j][k];
                    else
                        cols_o[DIGIT_W*(i+j) + k][COL_H0 - 1 - (i - diag_lo(i+j))] = pp[i][j][k];
                end
            end
        end
    end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import dm_pkg::*;
#(
    parameter int IN_H  = 15,
    parameter int OUT_H = st_out(IN_H)
) (
    input  logic [IN_H-1:0]  col_i [PROD_W],
    output logic [OUT_H-1:0] col_o [PROD_W]
);
    localparam int NF  = st_full(IN_H);
    localparam int REM = st_rem(IN_H);
    localparam int N3  = st_n3(IN_H);
    localparam int N2  = st_n2(IN_H);
    localparam int N1  = st_n1(IN_H);
    localparam int OWN = st_own(IN_H);
    localparam int UP1 = st_up1(IN_H);

    logic [COL_H0-1:0] slots;
    logic [2:0]        cnt3;
    logic [1:0]        cnt2;

    // Output slot layout per column: own-weight bits, then carries from
    // column c-1, then second-order carries from column c-2.
    always_comb begin
        slots = '0;
        cnt3  = '0;
        cnt2  = '0;
        for (int c = 0; c < PROD_W; c++) col_o[c] = '0;
        for (int c = 0; c < PROD_W; c++) begin
            slots = '0;
            slots[IN_H-1:0] = col_i[c];
            for (int g = 0; g < N3; g++) begin
                cnt3 = 3'(count_range(slots, g * CNT3_IN, (g < NF) ? CNT3_IN : REM));
                col_o[c][g] = cnt3[0];
                if (c + 1 < PROD_W) col_o[c+1][OWN + g] = cnt3[1];
                if (c + 2 < PROD_W) col_o[c+2][OWN + UP1 + g] = cnt3[2];
            end
            if (N2 == 1) begin
                cnt2 = 2'(count_range(slots, NF * CNT3_IN, REM));
                col_o[c][N3] = cnt2[0];
                if (c + 1 < PROD_W) col_o[c+1][OWN + N3] = cnt2[1];
            end
            if (N1 == 1) col_o[c][N3 + N2] = slots[IN_H-1];
        end
    end
endmodule

// File: rtl/digit_mult64.sv
module digit_mult64
    import dm_pkg::*;
#(
    parameter bit REG_IN  = 1'b1,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OP_W-1:0]     a_i,
    input  logic [OP_W-1:0]     b_i,
    output logic [PROD_W-1:0]   prod_o
);
    localparam int H1 = st_out(COL_H0);
    localparam int H2 = st_out(H1);
    localparam int H3 = st_out(H2);

    op_pair_t in_d, in_q;
    assign in_d = '{mcand: a_i, mplier: b_i};

    if (REG_IN) begin : g_in_reg
        always_ff @(posedge clk) begin
            if (rst) in_q <= '0;
            else     in_q <= in_d;
        end
    end else begin : g_in_pass
        assign in_q = in_d;
    end

    logic [COL_H0-1:0] col0 [PROD_W];
    logic [H1-1:0]     col1 [PROD_W];
    logic [H2-1:0]     col2 [PROD_W];
    logic [H3-1:0]     col3 [PROD_W];

    pp_gather u_gather (
        .op_a_i (in_q.mcand),
        .op_b_i (in_q.mplier),
        .cols_o (col0)
    );

    cnt_stage #(.IN_H(COL_H0), .OUT_H(H1)) u_lvl1 (.col_i(col0), .col_o(col1));
    cnt_stage #(.IN_H(H1),     .OUT_H(H2)) u_lvl2 (.col_i(col1), .col_o(col2));
    cnt_stage #(.IN_H(H2),     .OUT_H(H3)) u_lvl3 (.col_i(col2), .col_o(col3));

    product_t row_a, row_b, sum_d;

    always_comb begin
        for (int c = 0; c < PROD_W; c++) begin
            row_a[c] = col3[c][0];
            row_b[c] = col3[c][H3-1];
        end
        sum_d = row_a + row_b;
    end

    if (REG_OUT) begin : g_out_reg
        always_ff @(posedge clk) begin
            if (rst) prod_o <= '0;
            else     prod_o <= sum_d;
        end
    end else begin : g_out_pass
        assign prod_o = sum_d;
    end
endmodule

// File: rtl/digit_mult64_chk.sv
module digit_mult64_chk
    import dm_pkg::*;
#(
    parameter int LAT      = 2,
    parameter bit HAS_OREG = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   a_i,
    input logic [OP_W-1:0]   b_i,
    input logic [PROD_W-1:0] prod_o
);
    localparam product_t ONES_SQ = {{(OP_W-1){1'b1}}, 1'b0, {(OP_W-1){1'b0}}, 1'b1};

    if (LAT > 0) begin : g_pipe
        product_t  exp_q  [LAT];
        logic      zero_q [LAT];
        logic      one_q  [LAT];
        logic      ones_q [LAT];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < LAT; k++) begin
                    exp_q[k]  <= '0;
                    zero_q[k] <= 1'b0;
                    one_q[k]  <= 1'b0;
                    ones_q[k] <= 1'b0;
                end
            end else begin
                exp_q[0]  <= PROD_W'(a_i) * PROD_W'(b_i);
                zero_q[0] <= (a_i == '0) || (b_i == '0);
                one_q[0]  <= ($countones(a_i) == 1) && ($countones(b_i) == 1);
                ones_q[0] <= (&a_i) && (&b_i);
                for (int k = 1; k < LAT; k++) begin
                    exp_q[k]  <= exp_q[k-1];
                    zero_q[k] <= zero_q[k-1];
                    one_q[k]  <= one_q[k-1];
                    ones_q[k] <= ones_q[k-1];
                end
            end
        end

        // R1
        product_match_chk: assert property (@(posedge clk) disable iff (rst)
            prod_o == exp_q[LAT-1]);

        // R4
        zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
            zero_q[LAT-1] |-> prod_o == '0);

        // R6
        onehot_product_chk: assert property (@(posedge clk) disable iff (rst)
            one_q[LAT-1] |-> $countones(prod_o) == 1);

        // R5
        all_ones_chk: assert property (@(posedge clk) disable iff (rst)
            ones_q[LAT-1] |-> prod_o == ONES_SQ);
    end

    if (HAS_OREG) begin : g_rst_chk
        // R3
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> prod_o == '0);
    end
endmodule

bind digit_mult64 digit_mult64_chk #(
    .LAT      (int'(REG_IN) + int'(REG_OUT)),
    .HAS_OREG (REG_OUT)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_o)
);

// File: tb/digit_mult64_tb_top.sv
module digit_mult64_tb_top;

    localparam int LAT = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [63:0]  a_i = '0;
    logic [63:0]  b_i = '0;
    logic [127:0] prod_o;

    int n_checks = 0;
    int n_errs   = 0;

    always #2 clk = ~clk;

    digit_mult64 #(.REG_IN(1'b1), .REG_OUT(1'b1)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod_o)
    );

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [15:0] tag;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{64'h0,                  64'h0123_4567_89AB_CDEF, "R4"},
        '{64'hDEAD_BEEF_0000_1111, 64'h0,                  "R4"},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R5"},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1,                  "R1"},
        '{64'h1,                  64'h1,                  "R6"},
        '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R6"},
        '{64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, "R1"},
        '{64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, "R1"},
        '{64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, "R1"},
        '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R1"},
        '{64'hFF00_0000_0000_0000, 64'hFF00_0000_0000_0000, "R7"},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h2,                  "R1"}
    };

    function automatic logic [127:0] ref_mul(logic [63:0] a, logic [63:0] b);
        return 128'(a) * 128'(b);
    endfunction

    task automatic check128(input logic [127:0] act, input logic [127:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [63:0] a, input logic [63:0] b, output logic [127:0] got);
        @(negedge clk);
        a_i = a;
        b_i = b;
        repeat (LAT) @(negedge clk);
        got = prod_o;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin : main
        logic [127:0] got, got2, prev;
        logic [63:0]  ra, rb;

        // R3: reset with nonzero operands held on the inputs
        a_i = 64'hFFFF_FFFF_FFFF_FFFF;
        b_i = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        check128(prod_o, 128'h0, "R3 first edge");
        @(negedge clk);
        check128(prod_o, 128'h0, "R3 held");
        rst = 1'b0;
        repeat (LAT) @(negedge clk);
        check128(prod_o, ref_mul(a_i, b_i), "R3 release");

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            run_vec(VECS[v].a, VECS[v].b, got);
            check128(got, ref_mul(VECS[v].a, VECS[v].b), $sformatf("%s vec%0d", VECS[v].tag, v));
        end

        // R5: fixed expected constant
        run_vec('1, '1, got);
        check128(got, 128'hFFFF_FFFF_FFFF_FFFE_0000_0000_0000_0001, "R5 constant");

        // R2: latency and hold
        run_vec(64'h3, 64'h5, prev);
        @(negedge clk);
        a_i = 64'h7;
        b_i = 64'hB;
        @(negedge clk);
        check128(prod_o, prev, "R2 hold after one edge");
        @(negedge clk);
        check128(prod_o, 128'd77, "R2 after two edges");

        // R7: every digit pair at every offset
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                run_vec(64'hFF << (8*i), 64'hFF << (8*j), got);
                check128(got, 128'(16'hFE01) << (8*(i+j)), $sformatf("R7 digit %0d,%0d", i, j));
            end
        end

        // R6: single-bit operands
        for (int p = 0; p < 64; p += 7) begin
            for (int q = 0; q < 64; q += 9) begin
                run_vec(64'h1 << p, 64'h1 << q, got);
                check128(got, 128'h1 << (p+q), $sformatf("R6 bits %0d,%0d", p, q));
            end
        end

        // R4: zero against random operands
        for (int n = 0; n < 20; n++) begin
            ra = {$urandom, $urandom};
            run_vec(ra, 64'h0, got);
            check128(got, 128'h0, "R4 b zero");
            run_vec(64'h0, ra, got);
            check128(got, 128'h0, "R4 a zero");
        end

        // R8: operand swap
        for (int n = 0; n < 200; n++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            run_vec(ra, rb, got);
            run_vec(rb, ra, got2);
            check128(got2, got, "R8 swap");
        end

        // R3: mid-run reset
        run_vec(64'hABCD_0000_1234_FFFF, 64'h0F0F_0F0F_F0F0_F0F0, got);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check128(prod_o, 128'h0, "R3 mid-run");
        rst = 1'b0;
        repeat (LAT) @(negedge clk);
        check128(prod_o, ref_mul(a_i, b_i), "R3 mid-run release");

        // R1: random operand pairs
        for (int n = 0; n < 10000; n++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            run_vec(ra, rb, got);
            check128(got, ref_mul(ra, rb), "R1 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule